// File: doc/BRIEF.md
# FIFO Ticket Lock Unit

This block arbitrates one shared lock among a fixed set of requesters and serves them strictly in arrival order. It holds two counters: one that hands out places in line and one that names the ticket currently being served. A requester that raises its acquire line is given the next free ticket in a single atomic step. It then waits until its ticket is the one being served, holds the lock, and lets go by raising its release line. Letting go moves service on to the next ticket.

When several requesters ask in the same cycle, each gets a different, consecutive ticket. Lower requester indices get the lower numbers. A parameter picks how the owner is found. In compare mode each waiter's ticket is checked against the shared serving counter. In slot mode a ring of flag bits is kept, one per slot, and each waiter watches only the bit its ticket selects. For every requester the block also reports how far it stands from the head of the line, so that software can scale its backoff to the expected wait.

Top module: `tlk_unit`

## Requirements
- R1: After reset both counters read zero, no requester holds a ticket, no grant is given, the error flag is low, and the slot flags equal 1, meaning only slot 0 is marked.
- R2: A requester whose acquire line is high while it holds no ticket is given ticket = next-ticket value + (the number of lower-index requesters also newly acquiring that cycle). The next-ticket counter then advances by the number of new acquirers. Tickets, holding bits and the counter show the new values one cycle after the request.
- R3: An acquire from a requester that already holds a ticket is ignored. Its ticket is unchanged and the next-ticket counter does not count it.
- R4: A requester's grant is high exactly when it holds a ticket equal to the now-serving value. At most one grant is high at any time, so the lock is handed out in ticket order.
- R5: A release from the granted requester increments the now-serving counter by one and clears that requester's holding bit, both one cycle later.
- R6: In slot mode the flag vector has exactly one bit set, at bit index now-serving mod SLOTS. A valid release clears that bit and sets the next one. The grant is the flag selected by the holder's ticket mod SLOTS, and it equals the compare-mode grant in every cycle.
- R7: A release from a requester that is not granted changes neither counter nor any holding bit. It raises the error flag for exactly the following cycle.
- R8: The wait count of a holding requester is (ticket − now-serving) mod 2^TICKET_W. It reads 0 for a requester with no ticket.
- R9: Both counters are TICKET_W bits wide and wrap from 2^TICKET_W−1 to 0 with no break in service order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acqReq | input | NUM_REQ | Per-requester acquire strobe |
| relReq | input | NUM_REQ | Per-requester release strobe |
| tickets | output | NUM_REQ*TICKET_W | Ticket held by each requester, requester i in bits [i*TICKET_W +: TICKET_W] |
| holding | output | NUM_REQ | Requester holds a ticket (waiting or owning) |
| grant | output | NUM_REQ | Requester currently owns the lock |
| waitCount | output | NUM_REQ*TICKET_W | Distance of each requester from the head of the line |
| nextTicket | output | TICKET_W | Next ticket to be handed out |
| nowServing | output | TICKET_W | Ticket currently served |
| slotFlags | output | SLOTS | Ring of per-slot ownership flags |
| relErr | output | 1 | Pulses the cycle after a release from a non-owner |

## Verification
The hardest case to reach is a wrap of both counters past 2^TICKET_W−1 while several tickets are outstanding, so that the queue straddles the wrap and the slot ring wraps at the same time. Random acquire masks keep the line full, and a release biased toward the current owner keeps service moving. Together they carry the counters round the wrap many times in one run. Directed steps add the other cases: all requesters acquiring in one cycle, re-acquire while holding, and releases from waiters and from idle requesters. Every cycle is compared against a bench model and against a second instance built in compare mode.

// File: rtl/tlk_pkg.sv
package tlk_pkg;
  typedef struct packed {
    logic anyTake;
    logic relFire;
    logic relBad;
  } tlkStrobe_t;
endpackage

// File: rtl/tlk_ctrl.sv
module tlk_ctrl #(
  parameter int NUM_REQ = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_REQ-1:0]      acqReq,
  input  logic [NUM_REQ-1:0]      relReq,
  input  logic [NUM_REQ-1:0]      holding,
  input  logic [NUM_REQ-1:0]      grant,
  output logic [NUM_REQ-1:0]      takeMask,
  output logic [NUM_REQ-1:0]      relMask,
  output tlk_pkg::tlkStrobe_t     strobe,
  output logic                    relErr
);
  // only idle requesters may take a ticket; only the owner may release
  always_comb begin
    takeMask       = acqReq & ~holding;
    relMask        = relReq & grant;
    strobe.anyTake = |takeMask;
    strobe.relFire = |relMask;
    strobe.relBad  = |(relReq & ~grant);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) relErr <= 1'b0;
    else        relErr <= strobe.relBad;
  end
endmodule

// File: rtl/tlk_datapath.sv
module tlk_datapath #(
  parameter int NUM_REQ    = 4,
  parameter int TICKET_W   = 4,
  parameter int SLOTS      = 4,
  parameter bit ARRAY_MODE = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_REQ-1:0]           takeMask,
  input  logic [NUM_REQ-1:0]           relMask,
  input  tlk_pkg::tlkStrobe_t          strobe,
  output logic [NUM_REQ*TICKET_W-1:0]  tickets,
  output logic [NUM_REQ-1:0]           holding,
  output logic [NUM_REQ-1:0]           grant,
  output logic [NUM_REQ*TICKET_W-1:0]  waitCount,
  output logic [TICKET_W-1:0]          nextTicket,
  output logic [TICKET_W-1:0]          nowServing,
  output logic [SLOTS-1:0]             slotFlags
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [TICKET_W-1:0] tickReg    [NUM_REQ];
  logic [TICKET_W-1:0] assignTick [NUM_REQ];
  logic [TICKET_W-1:0] takeTotal;
  logic [SLOT_W-1:0]   curSlot;
  logic [SLOT_W-1:0]   nxtSlot;
  logic [SLOTS-1:0]    flagsNext;

  // consecutive tickets in requester-index order
  always_comb begin
    logic [TICKET_W-1:0] runOff;
    runOff = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      assignTick[i] = nextTicket + runOff;
      if (takeMask[i]) runOff = runOff + TICKET_W'(1);
    end
    takeTotal = runOff;
  end

  always_comb begin
    curSlot   = nowServing[SLOT_W-1:0];
    nxtSlot   = curSlot + SLOT_W'(1);
    flagsNext = slotFlags;
    if (strobe.relFire) begin
      flagsNext[curSlot] = 1'b0;
      flagsNext[nxtSlot] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nextTicket <= '0;
      nowServing <= '0;
      slotFlags  <= SLOTS'(1);
      holding    <= '0;
      for (int i = 0; i < NUM_REQ; i++) tickReg[i] <= '0;
    end else begin
      if (strobe.anyTake) nextTicket <= nextTicket + takeTotal;
      if (strobe.relFire) nowServing <= nowServing + TICKET_W'(1);
      slotFlags <= flagsNext;
      for (int i = 0; i < NUM_REQ; i++) begin
        if (takeMask[i]) begin
          tickReg[i] <= assignTick[i];
          holding[i] <= 1'b1;
        end else if (relMask[i]) begin
          holding[i] <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    assign tickets[g*TICKET_W +: TICKET_W]   = tickReg[g];
    assign waitCount[g*TICKET_W +: TICKET_W] = holding[g] ? (tickReg[g] - nowServing) : '0;
    if (ARRAY_MODE) begin : g_slot
      assign grant[g] = holding[g] & slotFlags[tickReg[g][SLOT_W-1:0]];
    end else begin : g_cmp
      assign grant[g] = holding[g] & (tickReg[g] == nowServing);
    end
  end
endmodule

// File: rtl/tlk_unit.sv
module tlk_unit #(
  parameter int NUM_REQ    = 4,
  parameter int TICKET_W   = 4,
  parameter int SLOTS      = 4,
  parameter bit ARRAY_MODE = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_REQ-1:0]           acqReq,
  input  logic [NUM_REQ-1:0]           relReq,
  output logic [NUM_REQ*TICKET_W-1:0]  tickets,
  output logic [NUM_REQ-1:0]           holding,
  output logic [NUM_REQ-1:0]           grant,
  output logic [NUM_REQ*TICKET_W-1:0]  waitCount,
  output logic [TICKET_W-1:0]          nextTicket,
  output logic [TICKET_W-1:0]          nowServing,
  output logic [SLOTS-1:0]             slotFlags,
  output logic                         relErr
);
  tlk_pkg::tlkStrobe_t strobe;
  logic [NUM_REQ-1:0]  takeMask;
  logic [NUM_REQ-1:0]  relMask;

  tlk_ctrl #(.NUM_REQ(NUM_REQ)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .acqReq(acqReq), .relReq(relReq),
    .holding(holding), .grant(grant), .takeMask(takeMask),
    .relMask(relMask), .strobe(strobe), .relErr(relErr)
  );

  tlk_datapath #(.NUM_REQ(NUM_REQ), .TICKET_W(TICKET_W), .SLOTS(SLOTS),
                 .ARRAY_MODE(ARRAY_MODE)) u_dp (
    .clk(clk), .rst_n(rst_n), .takeMask(takeMask), .relMask(relMask),
    .strobe(strobe), .tickets(tickets), .holding(holding), .grant(grant),
    .waitCount(waitCount), .nextTicket(nextTicket), .nowServing(nowServing),
    .slotFlags(slotFlags)
  );
endmodule

// File: rtl/tlk_checker.sv
module tlk_checker #(
  parameter int NUM_REQ  = 4,
  parameter int TICKET_W = 4,
  parameter int SLOTS    = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_REQ-1:0]           acqReq,
  input logic [NUM_REQ-1:0]           relReq,
  input logic [NUM_REQ-1:0]           holding,
  input logic [NUM_REQ-1:0]           grant,
  input logic [NUM_REQ*TICKET_W-1:0]  waitCount,
  input logic [TICKET_W-1:0]          nextTicket,
  input logic [TICKET_W-1:0]          nowServing,
  input logic [SLOTS-1:0]             slotFlags,
  input logic                         relErr
);
  logic [TICKET_W-1:0] newTakers;
  logic                badRel;
  logic                goodRel;
  logic                grantWaitBad;

  always_comb begin
    newTakers = TICKET_W'($countones(acqReq & ~holding));
    badRel    = |(relReq & ~grant);
    goodRel   = |(relReq & grant);
    grantWaitBad = 1'b0;
    for (int i = 0; i < NUM_REQ; i++)
      if (grant[i] && waitCount[i*TICKET_W +: TICKET_W] != '0) grantWaitBad = 1'b1;
  end

  p_next_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> nextTicket == $past(nextTicket) + $past(newTakers));

  p_one_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_grant_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~holding) == '0);

  p_serve_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    goodRel |=> nowServing == $past(nowServing) + TICKET_W'(1));

  p_serve_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !goodRel |=> $stable(nowServing));

  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> relErr == $past(badRel));

  p_flag_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slotFlags) == 1);

  p_owner_zero_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !grantWaitBad);
endmodule

bind tlk_unit tlk_checker #(.NUM_REQ(NUM_REQ), .TICKET_W(TICKET_W), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acqReq(acqReq), .relReq(relReq), .holding(holding),
  .grant(grant), .waitCount(waitCount), .nextTicket(nextTicket),
  .nowServing(nowServing), .slotFlags(slotFlags), .relErr(relErr)
);

// File: tb/tlk_unit_tb.sv
module tlk_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int TW = 4;
  localparam int SL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0] acqReq = '0;
  logic [NR-1:0] relReq = '0;
  logic [NR*TW-1:0] tickets, waitCount, ticketsC, waitCountC;
  logic [NR-1:0] holding, grant, holdingC, grantC;
  logic [TW-1:0] nextTicket, nowServing, nextTicketC, nowServingC;
  logic [SL-1:0] slotFlags, slotFlagsC;
  logic relErr, relErrC;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlk_unit #(.NUM_REQ(NR), .TICKET_W(TW), .SLOTS(SL), .ARRAY_MODE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .acqReq(acqReq), .relReq(relReq), .tickets(tickets),
    .holding(holding), .grant(grant), .waitCount(waitCount), .nextTicket(nextTicket),
    .nowServing(nowServing), .slotFlags(slotFlags), .relErr(relErr));

  tlk_unit #(.NUM_REQ(NR), .TICKET_W(TW), .SLOTS(SL), .ARRAY_MODE(1'b0)) u_dut_cmp (
    .clk(clk), .rst_n(rst_n), .acqReq(acqReq), .relReq(relReq), .tickets(ticketsC),
    .holding(holdingC), .grant(grantC), .waitCount(waitCountC), .nextTicket(nextTicketC),
    .nowServing(nowServingC), .slotFlags(slotFlagsC), .relErr(relErrC));

  int nRun = 0;
  int nFail = 0;
  int mNext, mServe, wraps;
  int mTick [NR];
  bit mHold [NR];
  bit mErr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit modelGrant(input int i);
    return mHold[i] && (mTick[i] == mServe);
  endfunction

  function automatic logic [NR-1:0] ownerMask();
    logic [NR-1:0] m = '0;
    for (int i = 0; i < NR; i++) m[i] = modelGrant(i);
    return m;
  endfunction

  task automatic modelStep(input logic [NR-1:0] a, input logic [NR-1:0] r);
    logic [NR-1:0] g = ownerMask();
    int off = 0;
    bit bad = 1'b0;
    bit fire = 1'b0;
    for (int i = 0; i < NR; i++) begin
      if (r[i] && !g[i]) bad = 1'b1;
      if (r[i] && g[i]) begin fire = 1'b1; mHold[i] = 1'b0; end
    end
    for (int i = 0; i < NR; i++) begin
      if (a[i] && !mHold[i] && !(r[i] && g[i])) begin
        mTick[i] = (mNext + off) % (1 << TW);
        mHold[i] = 1'b1;
        off++;
      end
    end
    mNext = (mNext + off) % (1 << TW);
    if (fire) begin
      if (mServe == (1 << TW) - 1) wraps++;
      mServe = (mServe + 1) % (1 << TW);
    end
    mErr = bad;
  endtask

  task automatic checkAll();
    chk(nextTicket == TW'(mNext), "R2 nextTicket", nextTicket, mNext);
    chk(nowServing == TW'(mServe), "R5 nowServing", nowServing, mServe);
    chk(slotFlags == SL'(1 << (mServe % SL)), "R6 slotFlags", slotFlags, 1 << (mServe % SL));
    chk(relErr == mErr, "R7 relErr", relErr, mErr);
    chk(nowServingC == TW'(mServe) && nextTicketC == TW'(mNext), "R9 cmp counters",
        nowServingC, mServe);
    for (int i = 0; i < NR; i++) begin
      chk(holding[i] == mHold[i], "R3 holding", holding[i], mHold[i]);
      chk(grant[i] == modelGrant(i), "R4 grant", grant[i], modelGrant(i));
      chk(grantC[i] == modelGrant(i), "R6 cmp-mode grant", grantC[i], modelGrant(i));
      if (mHold[i]) begin
        chk(tickets[i*TW +: TW] == TW'(mTick[i]), "R2 ticket", tickets[i*TW +: TW], mTick[i]);
        chk(waitCount[i*TW +: TW] == TW'((mTick[i] - mServe) & ((1 << TW) - 1)),
            "R8 waitCount", waitCount[i*TW +: TW], (mTick[i] - mServe) & ((1 << TW) - 1));
      end else begin
        chk(waitCount[i*TW +: TW] == '0, "R8 idle waitCount", waitCount[i*TW +: TW], 0);
      end
    end
  endtask

  task automatic step(input logic [NR-1:0] a, input logic [NR-1:0] r);
    @(negedge clk);
    acqReq = a;
    relReq = r;
    @(posedge clk);
    modelStep(a, r);
    #1;
    checkAll();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    mNext = 0; mServe = 0; mErr = 1'b0; wraps = 0;
    for (int i = 0; i < NR; i++) begin mTick[i] = 0; mHold[i] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(nextTicket == '0 && nowServing == '0, "R1 counters", nowServing, 0);
    chk(slotFlags == SL'(1), "R1 slotFlags", slotFlags, 1);
    chk(holding == '0 && grant == '0 && relErr == 1'b0, "R1 idle", holding, 0);

    // R2 all acquire together: tickets 0..3 in index order
    step(4'b1111, 4'b0000);
    // R3 re-acquire while holding is ignored
    step(4'b0101, 4'b0000);
    // R7 release from waiters and not from the owner
    step(4'b0000, 4'b1110);
    // R5 owner release
    step(4'b0000, 4'b0001);
    // R7 release from idle requester 0
    step(4'b0000, 4'b0001);
    step(4'b0000, 4'b0000);

    // random traffic, wraps counters many times (R9)
    for (int n = 0; n < 3000; n++) begin
      logic [NR-1:0] a, r;
      a = NR'($urandom) & NR'($urandom);
      if ($urandom % 8 == 0) r = NR'($urandom);
      else if ($urandom % 3 != 0) r = ownerMask();
      else r = '0;
      step(a, r);
    end
    chk(wraps > 2, "R9 serving counter wrapped", wraps, 3);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule